// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire serial audio stream into parallel stereo sample pairs. A bit clock, a frame clock and a data line arrive from outside. They run asynchronously to the core clock. They are brought into the core clock domain and sampled on each rising bit-clock edge. The framing and the word length come from two fields of a control word, so one instance can follow I2S, left-justified, right-justified and DSP framings at 16, 20 or 24 bits per channel. Data arrives in two's complement, most significant bit first.

Each complete stereo frame is offered once on a valid/ready output as a left and a right 24-bit sample. Shorter words sit at the top of the 24-bit field, so the sign bit stays at bit 23. The output holds one frame. While a frame waits for `out_ready`, its data stays stable. A frame that completes during that wait is dropped, so the producer is never stalled. The bit clock may stop between bits; only its rising edges count. After reset is released, the receiver does nothing until it sees the frame clock rise.

Top module: `audrx_top`

## Requirements
- R1: While and after reset, `out_valid` is 0 and both output samples read zero until the first frame is delivered.
- R2: After reset release the receiver ignores all serial input until the first rising edge of `lrclk`; no word that began before that edge is ever delivered.
- R3: Framing code 00 in `cfg_word[5:4]` selects I2S: `lrclk` low carries the left word, high carries the right word, and the MSB is sampled on the second rising bit-clock edge after the `lrclk` transition.
- R4: Framing code 01 selects left-justified: `lrclk` high carries the left word, low carries the right word, and the MSB is sampled on the first rising bit-clock edge after the transition.
- R5: Framing code 10 selects right-justified: `lrclk` high carries the left word, and the word is the last N bits sampled before the following `lrclk` transition; earlier bits in that half are discarded.
- R6: Framing code 11 selects DSP: a one-bit-wide high pulse on `lrclk` starts a frame, the left MSB follows on the next bit-clock edge, and the right word follows the left LSB with no gap; the `lrclk` level does not select a channel.
- R7: `cfg_word[9:8]` selects the word length N: 00 gives 24, 01 gives 20, 10 gives 16, 11 gives 24. In I2S, left-justified and DSP framing, bits after the Nth in a slot are ignored.
- R8: A word of N bits appears in bits 23 down to 24-N of its output sample, and the lower 24-N bits are zero.
- R9: Each complete frame yields one transfer. `out_valid` rises only after both words are in. It stays high, with `out_left` and `out_right` unchanged, until a cycle with `out_ready` high. It then drops unless a new frame is loaded in that same cycle.
- R10: A frame that completes while a held frame has not been accepted is discarded, and the held frame is unchanged.
- R11: The bit clock may pause low for any number of core cycles between bits without changing the received words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Control word: framing in bits 5:4, word length in bits 9:8 |
| bclk | input | 1 | Serial bit clock, may be gated |
| lrclk | input | 1 | Frame clock, runs continuously |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| out_valid | output | 1 | A stereo frame is held on the outputs |
| out_ready | input | 1 | Consumer accepts the held frame this cycle |
| out_left | output | 24 | Left sample, left-aligned |
| out_right | output | 24 | Right sample, left-aligned |

## Verification
The bench fills unused bit slots with ones. A receiver that counted bits wrongly, started one edge early or late in I2S or DSP framing, or kept the first bits of a right-justified half would then return corrupted samples instead of zero-padded ones. One run holds `lrclk` high across reset release, so a receiver that armed on the level rather than the rising edge would deliver a partial frame that the scoreboard does not expect. Other runs gate the bit clock in bursts, and hold `out_ready` low across several frames. A design that sampled on core-clock time rather than bit-clock edges, or that overwrote the held frame, would show a wrong or extra sample.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

  localparam int SW = 24;
  localparam int CW = $clog2(SW + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    LEN_24  = 2'b00,
    LEN_20  = 2'b01,
    LEN_16  = 2'b10,
    LEN_24B = 2'b11
  } len_e;

  function automatic logic [CW-1:0] word_bits(len_e l);
    case (l)
      LEN_20:  return CW'(20);
      LEN_16:  return CW'(16);
      default: return CW'(SW);
    endcase
  endfunction

  // Move the low N bits of a raw shift value to the top of the sample.
  function automatic logic [SW-1:0] align_word(logic [SW-1:0] raw, len_e l);
    case (l)
      LEN_20:  return {raw[19:0], 4'b0};
      LEN_16:  return {raw[15:0], 8'b0};
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] stg [STAGES+1];

  assign stg[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stg[s+1] <= stg[s];
  end

  always_ff @(posedge clk) q_d <= stg[STAGES];
  assign q = stg[STAGES];
endmodule

// File: rtl/audrx_deser.sv
module audrx_deser
  import audrx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          bit_en,
  input  logic          lr,
  input  logic          sd,
  input  fmt_e          fmt,
  input  len_e          len,
  output logic          frm_stb,
  output logic [SW-1:0] frm_left,
  output logic [SW-1:0] frm_right
);
  logic [SW-1:0] sr, sr_n, lbuf, done_raw, shifted, first;
  logic [CW-1:0] cnt, cnt_n, nbits;
  logic          busy, busy_n, pend, pend_n, slot, slot_n, lr_prev, lrp_n;
  logic          have_left, done, done_slot, chg, rise, start_mark;

  assign shifted    = {sr[SW-2:0], sd};
  assign first      = {{(SW-1){1'b0}}, sd};
  assign nbits      = word_bits(len);
  assign chg        = lr ^ lr_prev;
  assign rise       = lr & ~lr_prev;
  assign start_mark = (fmt == FMT_DSP) ? rise : chg;

  always_comb begin
    sr_n      = sr;
    cnt_n     = cnt;
    busy_n    = busy;
    pend_n    = pend;
    slot_n    = slot;
    lrp_n     = lr_prev;
    done      = 1'b0;
    done_slot = 1'b0;
    done_raw  = '0;
    if (bit_en) begin
      lrp_n = lr;
      if (fmt == FMT_RJ) begin
        // The half just ended: its last bits sit in the shift register.
        if (chg) begin
          done      = 1'b1;
          done_slot = ~lr_prev;
          done_raw  = sr;
          sr_n      = first;
        end else begin
          sr_n = shifted;
        end
      end else begin
        if (start_mark) begin
          if (fmt == FMT_LJ) begin
            sr_n   = first;
            cnt_n  = CW'(1);
            busy_n = 1'b1;
            pend_n = 1'b0;
            slot_n = ~lr;
          end else begin
            pend_n = 1'b1;
            busy_n = 1'b0;
            cnt_n  = '0;
            slot_n = (fmt == FMT_I2S) ? lr : 1'b0;
          end
        end else if (pend) begin
          sr_n   = first;
          cnt_n  = CW'(1);
          busy_n = 1'b1;
          pend_n = 1'b0;
        end else if (busy) begin
          sr_n  = shifted;
          cnt_n = cnt + CW'(1);
        end
        if (busy_n && (cnt_n == nbits)) begin
          done      = 1'b1;
          done_slot = slot_n;
          done_raw  = sr_n;
          if ((fmt == FMT_DSP) && !slot_n) begin
            slot_n = 1'b1;
            cnt_n  = '0;
            sr_n   = '0;
          end else begin
            busy_n = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      pend      <= 1'b0;
      slot      <= 1'b0;
      lr_prev   <= 1'b0;
      lbuf      <= '0;
      have_left <= 1'b0;
      frm_stb   <= 1'b0;
      frm_left  <= '0;
      frm_right <= '0;
    end else begin
      frm_stb <= 1'b0;
      if (!run) begin
        sr        <= '0;
        cnt       <= '0;
        busy      <= 1'b0;
        pend      <= 1'b0;
        slot      <= 1'b0;
        lr_prev   <= 1'b0;
        have_left <= 1'b0;
      end else begin
        sr      <= sr_n;
        cnt     <= cnt_n;
        busy    <= busy_n;
        pend    <= pend_n;
        slot    <= slot_n;
        lr_prev <= lrp_n;
        if (done) begin
          if (!done_slot) begin
            lbuf      <= align_word(done_raw, len);
            have_left <= 1'b1;
          end else if (have_left) begin
            frm_stb   <= 1'b1;
            frm_left  <= lbuf;
            frm_right <= align_word(done_raw, len);
            have_left <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audrx_outbuf.sv
module audrx_outbuf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_stb,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic slot_free;

  assign slot_free = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (in_stb && slot_free) begin
      out_valid <= 1'b1;
      out_left  <= in_left;
      out_right <= in_right;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/audrx_top.sv
module audrx_top
  import audrx_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int FMT_LSB     = 4,
  parameter int LEN_LSB     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cfg_word,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right
);
  localparam int NSIG = 3;
  localparam int IB   = 2;
  localparam int IL   = 1;
  localparam int ID   = 0;

  logic [NSIG-1:0] s_q, s_d;
  logic            bit_en, lr_rise, armed, frm_stb;
  logic [SW-1:0]   frm_left, frm_right;
  logic [CFG_W-1:0] cfg;
  fmt_e            fmt_sel;
  len_e            len_sel;

  assign cfg     = CFG_W'(cfg_word);
  assign fmt_sel = fmt_e'(cfg[FMT_LSB +: 2]);
  assign len_sel = len_e'(cfg[LEN_LSB +: 2]);

  audrx_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .din ({bclk, lrclk, sdata}),
    .q   (s_q),
    .q_d (s_d)
  );

  assign bit_en  = s_q[IB] & ~s_d[IB];
  assign lr_rise = s_q[IL] & ~s_d[IL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (lr_rise) armed <= 1'b1;
  end

  audrx_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (armed),
    .bit_en    (bit_en),
    .lr        (s_q[IL]),
    .sd        (s_q[ID]),
    .fmt       (fmt_sel),
    .len       (len_sel),
    .frm_stb   (frm_stb),
    .frm_left  (frm_left),
    .frm_right (frm_right)
  );

  audrx_outbuf #(.W(SW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stb    (frm_stb),
    .in_left   (frm_left),
    .in_right  (frm_right),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_left  (out_left),
    .out_right (out_right)
  );
endmodule

// File: rtl/audrx_chk.sv
module audrx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        armed,
  input logic        frm_stb,
  input logic [1:0]  len_sel,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_left,
  input logic [23:0] out_right
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  assert_rise_needs_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frm_stb));

  assert_quiet_until_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!out_valid && !frm_stb));

  assert_pad16_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && len_sel == 2'b10) |-> (out_left[7:0] == 8'h0 && out_right[7:0] == 8'h0));

  assert_pad20_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && len_sel == 2'b01) |-> (out_left[3:0] == 4'h0 && out_right[3:0] == 4'h0));
endmodule

bind audrx_top audrx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .armed     (armed),
  .frm_stb   (frm_stb),
  .len_sel   (len_sel),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/tb_audrx_top.sv
`timescale 1ns/1ps
module tb_audrx_top;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = 16'h0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0, out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int checks = 0, errors = 0, bitcnt = 0, burst = 0;
  bit done = 1'b0;
  logic [47:0] expq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  audrx_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  task automatic check(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 R9 unexpected frame", {out_left, out_right}, 48'h0);
      end else begin
        logic [47:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({out_left, out_right} === e, t, {out_left, out_right}, e);
      end
    end
  end

  task automatic bit_slot(logic lr, logic d);
    @(negedge clk);
    lrclk = lr;
    sdata = d;
    repeat (H) @(negedge clk);
    bclk = 1'b1;
    repeat (H) @(negedge clk);
    bclk = 1'b0;
    bitcnt++;
    if (burst != 0 && (bitcnt % 8) == 0) repeat (40) @(negedge clk);
  endtask

  function automatic int nbits(logic [1:0] len);
    return (len == 2'b01) ? 20 : (len == 2'b10) ? 16 : 24;
  endfunction

  // fmt: 0 I2S, 1 LJ, 2 RJ, 3 DSP. Unused slots carry ones.
  task automatic send_frame(logic [1:0] fmt, logic [1:0] len, logic [23:0] l,
                            logic [23:0] r, bit exp, string tag);
    int n;
    logic [23:0] m;
    n = nbits(len);
    m = 24'hFFFFFF << (24 - n);
    if (exp) begin
      expq.push_back({l & m, r & m});
      tagq.push_back(tag);
    end
    for (int k = 0; k < 64; k++) begin
      int i;
      logic [23:0] w;
      logic lr, d;
      i = k % 32;
      w = (k < 32) ? l : r;
      d = 1'b1;
      case (fmt)
        2'd0: begin
          lr = (k >= 32);
          if (i >= 1 && i <= n) d = w[24 - i];
        end
        2'd1: begin
          lr = (k < 32);
          if (i < n) d = w[23 - i];
        end
        2'd2: begin
          lr = (k < 32);
          if (i >= 32 - n) d = w[23 - (i - (32 - n))];
        end
        default: begin
          lr = (k == 0);
          if (k >= 1 && k <= n) d = l[24 - k];
          else if (k > n && k <= 2 * n) d = r[24 - (k - n)];
        end
      endcase
      bit_slot(lr, d);
    end
  endtask

  function automatic logic [23:0] smp(int seed, int idx);
    logic [31:0] v;
    v = 32'h9E3779B9 * (seed * 16 + idx + 1);
    return v[31:8];
  endfunction

  task automatic do_reset(logic [1:0] fmt, logic [1:0] len, logic lr_pre);
    rst_n = 1'b0;
    cfg_word = {6'b0, len, 2'b0, fmt, 4'b0};
    lrclk = lr_pre;
    bclk = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_seg(logic [1:0] fmt, logic [1:0] len, int brst, logic lr_pre,
                         int seed, string tag);
    burst = brst;
    do_reset(fmt, len, lr_pre);
    send_frame(fmt, len, smp(seed, 0), smp(seed, 1), (fmt != 2'd0) && !lr_pre, tag);
    send_frame(fmt, len, 24'h800000, 24'h7FFFFF, 1'b1, tag);
    for (int f = 0; f < 3; f++)
      send_frame(fmt, len, smp(seed, 2 * f + 2), smp(seed, 2 * f + 3), 1'b1, tag);
    send_frame(fmt, len, smp(seed, 9), smp(seed, 10), fmt != 2'd2, tag);
    repeat (100) @(negedge clk);
    check(expq.size() == 0, {tag, " frames missing"}, 48'(expq.size()), 48'h0);
    burst = 0;
  endtask

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", 48'(out_valid), 48'h0);
    do_reset(2'd0, 2'b00, 1'b0);
    check({out_valid, out_left, out_right} == 49'h0, "R1 outputs after reset",
          {out_left, out_right}, 48'h0);

    run_seg(2'd0, 2'b00, 0, 1'b0, 1, "R3 R7 R8 i2s24");
    run_seg(2'd0, 2'b10, 1, 1'b0, 2, "R3 R7 R8 R11 i2s16 burst");
    run_seg(2'd1, 2'b01, 0, 1'b0, 3, "R4 R7 R8 lj20");
    run_seg(2'd1, 2'b00, 0, 1'b1, 4, "R2 R4 lj24 level high at release");
    run_seg(2'd2, 2'b10, 0, 1'b0, 5, "R5 R7 R8 rj16");
    run_seg(2'd2, 2'b00, 1, 1'b0, 6, "R5 R11 rj24 burst");
    run_seg(2'd3, 2'b01, 0, 1'b0, 7, "R6 R7 R8 dsp20");
    run_seg(2'd3, 2'b11, 0, 1'b0, 8, "R6 R7 dsp code11");

    // Back-pressure: first frame held, later frames dropped.
    out_ready = 1'b0;
    do_reset(2'd1, 2'b00, 1'b0);
    send_frame(2'd1, 2'b00, 24'h123456, 24'hABCDEF, 1'b1, "R10 held frame");
    repeat (20) @(negedge clk);
    check(out_valid == 1'b1, "R9 valid while stalled", 48'(out_valid), 48'h1);
    held = out_left;
    send_frame(2'd1, 2'b00, 24'h0F0F0F, 24'hF0F0F0, 1'b0, "");
    send_frame(2'd1, 2'b00, 24'h555555, 24'hAAAAAA, 1'b0, "");
    check(out_left == held && out_right == 24'hABCDEF, "R10 held data unchanged",
          {out_left, out_right}, {held, 24'hABCDEF});
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid drops after accept", 48'(out_valid), 48'h0);
    check(expq.size() == 0, "R10 held frame delivered", 48'(expq.size()), 48'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule